// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Programming Controller

This block drives a small on-chip nonvolatile byte store of 64 locations of 8 bits. The store is modelled here as a register array whose erase and write phases take a fixed, parameterised number of cycles. A CPU reaches the controller through three registers: a control register, an address register and a data register. To start an operation, software first arms the controller. It must then request programming within a short window. The controller takes the target address and data from the registers at the moment programming starts. While the operation runs, every further control request is refused.

Three kinds of operation exist: erase then write, erase only, and write only. Erase sets a byte to all ones. A write can only clear bits. When programming starts, the controller holds the CPU for two cycles. When the operation completes, it raises a one-cycle completion pulse that can serve as an interrupt request.

There are two reset inputs. The system reset clears the CPU-side registers and the arming logic, but it leaves an operation that is already running alone, so that operation completes. Only the power-on reset clears the programming sequencer and fills the store with ones.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: Registers are selected by `reg_sel`: 0 selects control, 1 selects address, 2 selects data, and 3 reads as zero. The control register bit layout is: bit 0 is the read strobe and always reads 0, bit 1 is program/busy, bit 2 is master arm, and bits 5:4 are the mode. After reset, every register reads zero. After power-on, every store byte holds 0xFF.
- R2: A control write with bit 2 set and bit 1 clear, made while the controller is not armed, arms it. Control bit 2 then reads 1.
- R3: A control write with bit 1 set starts an operation only if the controller is armed. With the arming write at edge T, a program write at edges T+1 to T+4 starts the operation. A program write at T+5 or later does not. Setting bits 1 and 2 in the same write from the unarmed state does not start an operation.
- R4: If no operation starts, the arm bit clears by itself at edge T+4. Starting an operation also clears it.
- R5: Control bit 1 reads 1 from the start edge until completion. Erase-only and write-only operations last PHASE_CYC cycles (16 by default). Erase-then-write lasts 2*PHASE_CYC cycles.
- R6: While busy, control writes are ignored: no arming, no start, no read strobe, and no change to the mode bits.
- R7: The mode bits written with the program request select the operation. The codes are: 00 stores the data exactly; 01 sets the byte to 0xFF; 10 stores old AND data; 11 behaves as 00.
- R8: An operation uses the address and data held in the registers at the start edge. Later writes to those registers do not change its target or its value.
- R9: `cpu_halt` is high for exactly 2 cycles, starting at the start edge.
- R10: `done_irq` is high for exactly one cycle. That cycle begins at the edge where busy clears.
- R11: If `rst_n` is asserted during an operation, the operation still completes and updates the store, and `done_irq` still pulses. The CPU-side registers read zero during reset, except that the busy bit stays 1.
- R12: A control write with bit 0 set, made while the controller is not busy, loads the data register from the byte at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the sequencer and fills the store with ones |
| rst_n | input | 1 | System reset, active low; clears the CPU-side registers only |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| cpu_halt | output | 1 | CPU hold while programming starts |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a system reset that arrives in the middle of a running operation. The stimulus pulses `rst_n` a few cycles after a start. It then confirms, through the control register, that busy remains set while the other fields read zero, and that the store byte is still updated. The second hard case is the edge of the arming window. Directed runs place the program request at exactly the last accepted edge and at the first refused edge. Random runs then spread the arm-to-program delay across both sides of the window.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      MODE_ERASE_WRITE = 2'b00,
      MODE_ERASE_ONLY  = 2'b01,
      MODE_WRITE_ONLY  = 2'b10,
      MODE_RESERVED    = 2'b11
   } nvm_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_ERASE = 2'b01,
      PH_WRITE = 2'b10
   } nvm_phase_e;

   localparam int CTL_READ   = 0;
   localparam int CTL_PROG   = 1;
   localparam int CTL_MASTER = 2;
   localparam int CTL_MODE   = 4;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_ADDR = 2'd1;
   localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
   parameter int ARM_WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic consume,
   output logic armed
);
   localparam int CW = $clog2(ARM_WIN + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         left_q <= '0;
      end else if (arm_set) begin
         armed  <= 1'b1;
         left_q <= CW'(ARM_WIN - 1);
      end else if (consume) begin
         armed  <= 1'b0;
      end else if (armed) begin
         if (left_q == '0) armed <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/nvm_prog_engine.sv
module nvm_prog_engine
   import nvm_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int PHASE_CYC = 16,
   parameter int HALT_CYC  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              start,
   input  logic [1:0]        start_mode,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_data,
   output logic              busy,
   output logic              halt,
   output logic              done,
   output logic              erase_en,
   output logic              write_en,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);
   localparam int PW = $clog2(PHASE_CYC + 1);
   localparam int HW = $clog2(HALT_CYC + 1);

   nvm_phase_e    phase_q;
   nvm_mode_e     mode_q;
   logic [PW-1:0] cnt_q;
   logic [HW-1:0] halt_q;
   logic          phase_end;

   assign phase_end = (cnt_q == '0);
   assign erase_en  = (phase_q == PH_ERASE) && phase_end;
   assign write_en  = (phase_q == PH_WRITE) && phase_end;
   assign busy      = (phase_q != PH_IDLE);
   assign halt      = (halt_q != '0);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q <= PH_IDLE;
         mode_q  <= MODE_ERASE_WRITE;
         cnt_q   <= '0;
         op_addr <= '0;
         op_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (start) begin
               mode_q  <= nvm_mode_e'(start_mode);
               op_addr <= start_addr;
               op_data <= start_data;
               cnt_q   <= PW'(PHASE_CYC - 1);
               phase_q <= (nvm_mode_e'(start_mode) == MODE_WRITE_ONLY) ? PH_WRITE : PH_ERASE;
            end
            PH_ERASE: if (phase_end) begin
               if (mode_q == MODE_ERASE_ONLY) begin
                  phase_q <= PH_IDLE;
                  done    <= 1'b1;
               end else begin
                  phase_q <= PH_WRITE;
                  cnt_q   <= PW'(PHASE_CYC - 1);
               end
            end else cnt_q <= cnt_q - 1'b1;
            PH_WRITE: if (phase_end) begin
               phase_q <= PH_IDLE;
               done    <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                         halt_q <= '0;
      else if (start && phase_q == PH_IDLE) halt_q <= HW'(HALT_CYC);
      else if (halt_q != '0)              halt_q <= halt_q - 1'b1;
   end
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     erase_en,
   input  logic                     write_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [DATA_W-1:0]        rd_data
);
   logic [DATA_W-1:0] cells_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [DATA_W-1:0] row_q;
      logic              hit;
      assign hit = (wr_addr == i[$clog2(DEPTH)-1:0]);
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                row_q <= '1;
         else if (erase_en && hit)  row_q <= '1;
         else if (write_en && hit)  row_q <= row_q & wr_data;
      end
      assign cells_w[i] = row_q;
   end

   assign rd_data = cells_w[rd_addr];
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
   import nvm_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int DATA_W    = 8,
   parameter int PHASE_CYC = 16,
   parameter int ARM_WIN   = 4,
   parameter int HALT_CYC  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              cpu_halt,
   output logic              done_irq
);
   localparam int ADDR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 6 || DATA_W < ADDR_W) begin : g_bad_width
      $error("DATA_W must hold the control fields and the address");
   end
   if (PHASE_CYC < 1 || ARM_WIN < 1 || HALT_CYC < 1) begin : g_bad_timing
      $error("PHASE_CYC, ARM_WIN and HALT_CYC must be positive");
   end

   logic              cpu_rst_n;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [1:0]        mode_q;
   logic              armed;
   logic              prog_busy;
   logic              ctrl_wr;
   logic              arm_set;
   logic              start;
   logic              read_go;
   logic              erase_en;
   logic              write_en;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] cell_rd;
   logic [DATA_W-1:0] ctrl_view;
   logic [DATA_W-1:0] addr_view;

   assign cpu_rst_n = rst_n & por_n;
   assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL) && !prog_busy;
   assign arm_set   = ctrl_wr && reg_wdata[CTL_MASTER] && !reg_wdata[CTL_PROG] && !armed;
   assign start     = ctrl_wr && reg_wdata[CTL_PROG] && armed;
   assign read_go   = ctrl_wr && reg_wdata[CTL_READ] && !reg_wdata[CTL_PROG];

   always_ff @(posedge clk or negedge cpu_rst_n) begin
      if (!cpu_rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         mode_q <= '0;
      end else begin
         if (reg_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
         if (reg_wr && reg_sel == SEL_DATA) data_q <= reg_wdata;
         else if (read_go)                  data_q <= cell_rd;
         if (ctrl_wr) mode_q <= reg_wdata[CTL_MODE +: 2];
      end
   end

   nvm_arm_window #(.ARM_WIN(ARM_WIN)) u_arm (
      .clk     (clk),
      .rst_n   (cpu_rst_n),
      .arm_set (arm_set),
      .consume (start),
      .armed   (armed)
   );

   nvm_prog_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_CYC(PHASE_CYC), .HALT_CYC(HALT_CYC)
   ) u_eng (
      .clk        (clk),
      .por_n      (por_n),
      .start      (start),
      .start_mode (reg_wdata[CTL_MODE +: 2]),
      .start_addr (addr_q),
      .start_data (data_q),
      .busy       (prog_busy),
      .halt       (cpu_halt),
      .done       (done_irq),
      .erase_en   (erase_en),
      .write_en   (write_en),
      .op_addr    (op_addr),
      .op_data    (op_data)
   );

   nvm_cell_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_cells (
      .clk      (clk),
      .por_n    (por_n),
      .erase_en (erase_en),
      .write_en (write_en),
      .wr_addr  (op_addr),
      .wr_data  (op_data),
      .rd_addr  (addr_q),
      .rd_data  (cell_rd)
   );

   always_comb begin
      ctrl_view               = '0;
      ctrl_view[CTL_PROG]     = prog_busy;
      ctrl_view[CTL_MASTER]   = armed;
      ctrl_view[CTL_MODE +: 2] = mode_q;
   end

   if (DATA_W > ADDR_W) begin : g_addr_pad
      assign addr_view = {{(DATA_W - ADDR_W){1'b0}}, addr_q};
   end else begin : g_addr_full
      assign addr_view = addr_q;
   end

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL: reg_rdata = ctrl_view;
         SEL_ADDR: reg_rdata = addr_view;
         SEL_DATA: reg_rdata = data_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk #(
   parameter int ARM_WIN = 4
) (
   input logic clk,
   input logic por_n,
   input logic rst_n,
   input logic busy,
   input logic armed,
   input logic cpu_halt,
   input logic done_irq
);
   localparam int CW = $clog2(ARM_WIN + 2);

   logic [CW-1:0] arm_age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     arm_age <= '0;
      else if (armed) arm_age <= arm_age + 1'b1;
      else            arm_age <= '0;
   end

   p_arm_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (arm_age < CW'(ARM_WIN)));

   p_arm_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !armed);

   p_halt_len_r9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_halt) |=> cpu_halt ##1 !cpu_halt);

   p_halt_start_r9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy) |-> cpu_halt);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
      done_irq |=> !done_irq);

   p_done_end_r10: assert property (@(posedge clk) disable iff (!por_n)
      $fell(busy) |-> done_irq);

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!por_n)
      done_irq |-> !busy);

   p_run_on_r11: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !rst_n && !done_irq) |=> (busy || done_irq));
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(.ARM_WIN(ARM_WIN)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .rst_n    (cpu_rst_n),
   .busy     (prog_busy),
   .armed    (armed),
   .cpu_halt (cpu_halt),
   .done_irq (done_irq)
);

// File: tb/sim_nvm_prog_ctrl.sv
module sim_nvm_prog_ctrl;
   localparam int PH = 16;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       cpu_halt;
   logic       done_irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] model [64];

   always #4 clk = ~clk;

   nvm_prog_ctrl u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_halt(cpu_halt), .done_irq(done_irq)
   );

   function automatic logic [7:0] expect_val(input logic [1:0] m, input logic [7:0] old_v,
                                             input logic [7:0] d);
      case (m)
         2'b01:   return 8'hFF;
         2'b10:   return old_v & d;
         default: return d;
      endcase
   endfunction

   function automatic int expect_len(input logic [1:0] m);
      return (m == 2'b01 || m == 2'b10) ? PH : 2 * PH;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // called at a negedge; the write lands on the next posedge; returns at the following negedge
   task automatic wr(input logic [1:0] s, input logic [7:0] v);
      reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      reg_sel = s;
      #1 v = reg_rdata;
   endtask

   task automatic read_back(input logic [5:0] a, input string req);
      logic [7:0] v;
      wr(2'd1, {2'b0, a});
      wr(2'd0, 8'h01);
      rd(2'd2, v);
      check(req, v, model[a]);
   endtask

   // count busy, halt and done cycles until idle; optional reset pulse at iterations 4..6
   task automatic track(input logic [1:0] m, input bit pulse_rst, input string req);
      logic [7:0] v;
      int nb = 0, nh = 0, nd = 0;
      for (int c = 0; c < 200; c++) begin
         if (pulse_rst && c == 4) rst_n = 1'b0;
         if (pulse_rst && c == 7) rst_n = 1'b1;
         rd(2'd0, v);
         if (pulse_rst && c == 5) check("R11 ctrl during reset", v, 8'h02);
         if (v[1]) nb++;
         if (cpu_halt) nh++;
         if (done_irq) nd++;
         if (!v[1]) break;
         @(negedge clk);
      end
      check({req, " R5 busy length"}, nb, expect_len(m));
      check("R9 halt cycles", nh, 2);
      check("R10 done seen at busy clear", nd, 1);
      @(negedge clk);
      check("R10 done one cycle", done_irq, 0);
   endtask

   task automatic run_op(input logic [5:0] a, input logic [7:0] d, input logic [1:0] m,
                         input int dly);
      logic [7:0] v;
      wr(2'd1, {2'b0, a});
      wr(2'd2, d);
      wr(2'd0, {2'b0, m, 4'b0100});
      repeat (dly) @(negedge clk);
      wr(2'd0, {2'b0, m, 4'b0010});
      rd(2'd0, v);
      if (dly <= 3) begin
         check("R3 start inside window", v[1], 1);
         check("R4 arm cleared by start", v[2], 0);
         track(m, 1'b0, "R7");
         model[a] = expect_val(m, model[a], d);
      end else begin
         check("R3 no start after window", v[1], 0);
         check("R4 arm expired", v[2], 0);
      end
      read_back(a, "R7/R12 stored value");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);

      rd(2'd0, v); check("R1 ctrl reset", v, 0);
      rd(2'd1, v); check("R1 addr reset", v, 0);
      rd(2'd2, v); check("R1 data reset", v, 0);
      rd(2'd3, v); check("R1 unused select", v, 0);
      read_back(6'd17, "R1 erased at power-on");

      // arming and self-clear timing
      wr(2'd0, 8'h04);
      rd(2'd0, v); check("R2 arm bit set", v, 8'h04);
      repeat (3) @(negedge clk);
      rd(2'd0, v); check("R4 arm still set at T+4 minus", v[2], 1);
      @(negedge clk);
      rd(2'd0, v); check("R4 arm self-clear", v[2], 0);

      // arm and program in one write does not start
      wr(2'd0, 8'h06);
      rd(2'd0, v); check("R3 same-write no start", v, 0);

      // window edges
      run_op(6'd5, 8'h3C, 2'b00, 3);
      run_op(6'd6, 8'h11, 2'b00, 4);
      run_op(6'd7, 8'hA5, 2'b11, 0);
      run_op(6'd5, 8'h0F, 2'b10, 1);
      run_op(6'd5, 8'h00, 2'b01, 2);

      // ignored control while busy, captured address and data
      wr(2'd1, 8'd9);
      wr(2'd2, 8'h5A);
      wr(2'd0, 8'h14);
      wr(2'd0, 8'h12);
      wr(2'd0, 8'h35);
      rd(2'd0, v); check("R6 ctrl write ignored while busy", v, 8'h12);
      rd(2'd2, v); check("R6 read strobe ignored while busy", v, 8'h5A);
      wr(2'd1, 8'd10);
      wr(2'd2, 8'h00);
      for (int c = 0; c < 100; c++) begin
         rd(2'd0, v);
         if (!v[1]) break;
         @(negedge clk);
      end
      model[9] = expect_val(2'b01, model[9], 8'h5A);
      read_back(6'd9, "R8 captured address");
      read_back(6'd10, "R8 other address untouched");

      // system reset during an operation
      wr(2'd1, 8'd33);
      wr(2'd2, 8'hC3);
      wr(2'd0, 8'h04);
      wr(2'd0, 8'h02);
      track(2'b00, 1'b1, "R11");
      model[33] = 8'hC3;
      rd(2'd1, v); check("R11 addr cleared by reset", v, 0);
      read_back(6'd33, "R11 operation completed");

      // constrained random operations
      for (int k = 0; k < 24; k++) begin
         logic [5:0] a;
         logic [7:0] d;
         logic [1:0] m;
         int dly;
         a = 6'($urandom_range(0, 7));
         d = 8'($urandom);
         m = 2'($urandom_range(0, 3));
         dly = $urandom_range(0, 5);
         run_op(a, d, m, dly);
      end

      finish_run();
   end
endmodule